// File: doc/BRIEF.md
# Strobe-Edge Delay Tracking Loop

This block keeps a programmable delay code lined up with the rising edge of an incoming data-clock strobe. Two samples of the delayed strobe come in each cycle. The early sample is taken at the current delay code. The late sample is taken a programmable skew further along the delay line. The delay is centred on the edge when the early sample reads 0 and the late sample reads 1. Otherwise the loop moves the code one fine-delay tap toward the edge.

Decisions are not made sample by sample. An averaging window collects votes over `(16 - skew) * AVG_UNIT` cycles, and the majority decides one step at most. A small skew code therefore gives a narrow capture window and a slow loop. A second output carries the code for the data-sample delay path. It follows the strobe code by a fixed offset, which is zero by default. The controller is armed by a two-step control write. It declares lock after a run of aligned windows and keeps correcting drift in the background once locked.

Top module: `strobe_track_loop`

## Requirements
- R1: After reset, `strobe_dly` and `sample_dly` both equal 167 and `status` is 0x00.
- R2: `ctrl[0]` is the enable bit and `ctrl[1]` is the track bit. The loop starts only after `ctrl` = 2'b10 (armed) is followed by `ctrl` = 2'b11. Writing 2'b11 from idle without arming first has no effect. While armed, the codes do not move.
- R3: When the majority of a window's samples have both PRE and PST at 1, the code drops by one at the end of that window. When the majority have both at 0, it rises by one. There is never more than one step per window, and the first step lands 17 cycles after the loop starts when `skew` is 15 and AVG_UNIT is 16.
- R4: When the majority of a window's samples are aligned (PRE = 0 and PST = 1), the code is held.
- R5: The window length is `(16 - skew) * AVG_UNIT` cycles. With `skew` = 0 the first step takes 16 times as long as with `skew` = 15.
- R6: Lock is declared after 8 consecutive aligned windows. `status` is then 0x05, where bit 0 means locked and bit 2 means tracking. While idle, armed or searching, `status` reads 0x00.
- R7: Lock is dropped after 4 consecutive windows that are not aligned, and `status` returns to 0x00. The loop keeps stepping the whole time, so it re-acquires the edge after drift.
- R8: The code saturates at 0 and at 1023 and never wraps.
- R9: `sample_dly` always equals `strobe_dly` plus the fixed offset, which is 0 by default.
- R10: Writing `ctrl` = 2'b00, or any value other than 2'b11, while the loop is running returns it to idle. `status` then reads 0x00 and both codes keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 2 | Bit 1 = track, bit 0 = enable |
| skew | input | 4 | Window width in fine-delay taps; also sets the averaging length |
| pre_smp | input | 1 | Strobe sampled at the current delay code |
| pst_smp | input | 1 | Strobe sampled skew + 1 taps later |
| strobe_dly | output | 10 | Delay code for the strobe path |
| sample_dly | output | 10 | Delay code for the data-sample path |
| status | output | 8 | 0x05 when locked and tracking, 0x00 otherwise |

## Verification
The hardest state to reach is losing lock and then winning it back. That needs a real lock first, then a strobe edge that jumps outside the window, then four consecutive misaligned windows while the code is still climbing. The bench models the edge position and drives both samples from the live delay code. It locks the loop and then moves the edge by 40 taps, so the drop and the later re-acquisition both come from the loop's own motion. The averaging unit is shortened in the bench, which lets both saturation limits be reached within the run.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int CODE_W_DEF   = 10;
    localparam int SKEW_W_DEF   = 4;
    localparam int CODE_RST_DEF = 167;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SEARCH = 2'd2,
        ST_LOCK   = 2'd3
    } stk_state_e;

    typedef enum logic [1:0] {
        V_ALIGNED = 2'd0,
        V_INC     = 2'd1,
        V_DEC     = 2'd2,
        V_MIXED   = 2'd3
    } verdict_e;

    typedef struct packed {
        logic     vld;
        verdict_e kind;
    } verdict_t;

    // window length in cycles for a given skew code
    function automatic int unsigned avg_len(input int unsigned skew_code,
                                            input int unsigned steps,
                                            input int unsigned unit);
        return (steps - skew_code) * unit;
    endfunction

    // majority decision over one averaging window
    function automatic verdict_e classify(input int unsigned n_early,
                                          input int unsigned n_late,
                                          input int unsigned n_algn,
                                          input int unsigned len);
        if (2 * n_late > len)       return V_DEC;
        else if (2 * n_early > len) return V_INC;
        else if (2 * n_algn > len)  return V_ALIGNED;
        else                        return V_MIXED;
    endfunction

endpackage

// File: rtl/stk_window_avg.sv
module stk_window_avg
    import stk_pkg::*;
#(
    parameter int SKEW_W   = SKEW_W_DEF,
    parameter int AVG_UNIT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [SKEW_W-1:0] skew,
    input  logic              pre_smp,
    input  logic              pst_smp,
    output verdict_t          verdict
);
    localparam int STEPS   = 2 ** SKEW_W;
    localparam int LEN_MAX = STEPS * AVG_UNIT;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    logic [CNT_W-1:0] cnt, len;
    logic [CNT_W-1:0] n_early, n_late, n_algn;
    logic [CNT_W-1:0] t_early, t_late, t_algn;
    logic             expire;

    always_comb begin
        len     = CNT_W'(avg_len(32'(skew), STEPS, AVG_UNIT));
        t_early = n_early + CNT_W'(!pre_smp && !pst_smp);
        t_late  = n_late  + CNT_W'(pre_smp && pst_smp);
        t_algn  = n_algn  + CNT_W'(!pre_smp && pst_smp);
        expire  = (cnt >= len - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt          <= '0;
            n_early      <= '0;
            n_late       <= '0;
            n_algn       <= '0;
            verdict.vld  <= 1'b0;
            verdict.kind <= V_MIXED;
        end else begin
            verdict.vld <= expire;
            if (expire) begin
                verdict.kind <= classify(32'(t_early), 32'(t_late),
                                         32'(t_algn), 32'(len));
                cnt     <= '0;
                n_early <= '0;
                n_late  <= '0;
                n_algn  <= '0;
            end else begin
                cnt     <= cnt + CNT_W'(1);
                n_early <= t_early;
                n_late  <= t_late;
                n_algn  <= t_algn;
            end
        end
    end
endmodule

// File: rtl/stk_mode_fsm.sv
module stk_mode_fsm
    import stk_pkg::*;
#(
    parameter int LOCK_N   = 8,
    parameter int UNLOCK_N = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ctrl,
    input  verdict_t   verdict,
    output logic       active,
    output logic [7:0] status
);
    localparam int LK_W = $clog2(LOCK_N + 1);
    localparam int UL_W = $clog2(UNLOCK_N + 1);

    stk_state_e      state;
    logic [LK_W-1:0] align_run;
    logic [UL_W-1:0] miss_run;
    logic            good;

    assign good = (verdict.kind == V_ALIGNED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            align_run <= '0;
            miss_run  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    align_run <= '0;
                    miss_run  <= '0;
                    if (ctrl == 2'b10) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (ctrl == 2'b11)      state <= ST_SEARCH;
                    else if (ctrl != 2'b10) state <= ST_IDLE;
                end
                ST_SEARCH: begin
                    if (ctrl != 2'b11) begin
                        state <= ST_IDLE;
                    end else if (verdict.vld) begin
                        if (!good) begin
                            align_run <= '0;
                        end else if (align_run == LK_W'(LOCK_N - 1)) begin
                            align_run <= '0;
                            miss_run  <= '0;
                            state     <= ST_LOCK;
                        end else begin
                            align_run <= align_run + LK_W'(1);
                        end
                    end
                end
                default: begin
                    if (ctrl != 2'b11) begin
                        state <= ST_IDLE;
                    end else if (verdict.vld) begin
                        if (good) begin
                            miss_run <= '0;
                        end else if (miss_run == UL_W'(UNLOCK_N - 1)) begin
                            miss_run  <= '0;
                            align_run <= '0;
                            state     <= ST_SEARCH;
                        end else begin
                            miss_run <= miss_run + UL_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        active = (state == ST_SEARCH) || (state == ST_LOCK);
        status = 8'h00;
        if (state == ST_LOCK) begin
            status[0] = 1'b1;
            status[2] = 1'b1;
        end
    end
endmodule

// File: rtl/stk_delay_reg.sv
module stk_delay_reg
    import stk_pkg::*;
#(
    parameter int CODE_W    = CODE_W_DEF,
    parameter int CODE_INIT = CODE_RST_DEF,
    parameter int CODE_OFS  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  verdict_t          verdict,
    output logic [CODE_W-1:0] strobe_code,
    output logic [CODE_W-1:0] sample_code
);
    localparam logic [CODE_W-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_code <= CODE_W'(CODE_INIT);
        end else if (active && verdict.vld) begin
            if (verdict.kind == V_INC && strobe_code != CMAX)
                strobe_code <= strobe_code + CODE_W'(1);
            else if (verdict.kind == V_DEC && strobe_code != '0)
                strobe_code <= strobe_code - CODE_W'(1);
        end
    end

    generate
        if (CODE_OFS == 0) begin : g_same
            assign sample_code = strobe_code;
        end else begin : g_offset
            always_comb begin
                int s;
                s = int'(strobe_code) + CODE_OFS;
                if (s < 0)                s = 0;
                else if (s > int'(CMAX))  s = int'(CMAX);
                sample_code = CODE_W'(s);
            end
        end
    endgenerate
endmodule

// File: rtl/strobe_track_loop.sv
module strobe_track_loop
    import stk_pkg::*;
#(
    parameter int CODE_W    = CODE_W_DEF,
    parameter int SKEW_W    = SKEW_W_DEF,
    parameter int AVG_UNIT  = 256,
    parameter int CODE_INIT = CODE_RST_DEF,
    parameter int CODE_OFS  = 0,
    parameter int LOCK_N    = 8,
    parameter int UNLOCK_N  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ctrl,
    input  logic [SKEW_W-1:0] skew,
    input  logic              pre_smp,
    input  logic              pst_smp,
    output logic [CODE_W-1:0] strobe_dly,
    output logic [CODE_W-1:0] sample_dly,
    output logic [7:0]        status
);
    verdict_t verdict;
    logic     active;

    stk_window_avg #(.SKEW_W(SKEW_W), .AVG_UNIT(AVG_UNIT)) u_avg (
        .clk(clk), .rst(rst), .run(active), .skew(skew),
        .pre_smp(pre_smp), .pst_smp(pst_smp), .verdict(verdict)
    );

    stk_mode_fsm #(.LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_fsm (
        .clk(clk), .rst(rst), .ctrl(ctrl), .verdict(verdict),
        .active(active), .status(status)
    );

    stk_delay_reg #(.CODE_W(CODE_W), .CODE_INIT(CODE_INIT), .CODE_OFS(CODE_OFS)) u_code (
        .clk(clk), .rst(rst), .active(active), .verdict(verdict),
        .strobe_code(strobe_dly), .sample_code(sample_dly)
    );
endmodule

// File: rtl/strobe_track_loop_chk.sv
module strobe_track_loop_chk #(
    parameter int CODE_W   = 10,
    parameter int CODE_OFS = 0
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        ctrl,
    input logic [CODE_W-1:0] strobe_dly,
    input logic [CODE_W-1:0] sample_dly,
    input logic [7:0]        status
);
    // R3: the code moves by at most one tap per cycle
    p_step_unit_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe_dly != $past(strobe_dly)) |->
            ((CODE_W+1)'(strobe_dly) == (CODE_W+1)'($past(strobe_dly)) + 1 ||
             (CODE_W+1)'(strobe_dly) + 1 == (CODE_W+1)'($past(strobe_dly))));

    // R6: status takes only the two legal values
    p_status_legal_r6: assert property (@(posedge clk) disable iff (rst)
        (status == 8'h00 || status == 8'h05));

    // R2: lock is only reported while the control word held 2'b11
    p_status_needs_ctrl_r2: assert property (@(posedge clk) disable iff (rst)
        (status != 8'h00) |-> ($past(ctrl) == 2'b11));

    // R10: once disabled for two cycles, the code is frozen
    p_frozen_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl == 2'b00, 2) && $past(ctrl == 2'b00)) |-> $stable(strobe_dly));

    // R9: the sample path tracks the strobe path
    p_sample_tracks_r9: assert property (@(posedge clk) disable iff (rst)
        (CODE_OFS == 0) |-> (sample_dly == strobe_dly));
endmodule

bind strobe_track_loop strobe_track_loop_chk #(.CODE_W(CODE_W), .CODE_OFS(CODE_OFS)) u_chk (
    .clk(clk), .rst(rst), .ctrl(ctrl), .strobe_dly(strobe_dly),
    .sample_dly(sample_dly), .status(status)
);

// File: tb/strobe_track_loop_test.sv
`timescale 1ns/1ps
module strobe_track_loop_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ctrl = 2'b00;
    logic [3:0] skew = 4'd15;
    logic       pre_smp = 1'b0;
    logic       pst_smp = 1'b0;
    logic [9:0] strobe_dly, sample_dly;
    logic [7:0] status;

    int edge_pos = 300;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    strobe_track_loop #(.AVG_UNIT(16)) uut (
        .clk(clk), .rst(rst), .ctrl(ctrl), .skew(skew),
        .pre_smp(pre_smp), .pst_smp(pst_smp),
        .strobe_dly(strobe_dly), .sample_dly(sample_dly), .status(status)
    );

    // strobe edge model: a tap reads 1 once it is at or past the edge
    always @(negedge clk) begin
        pre_smp <= (int'(strobe_dly) >= edge_pos);
        pst_smp <= (int'(strobe_dly) + int'(skew) + 1 >= edge_pos);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        n_run++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_status(input int v, input int limit);
        for (int i = 0; i < limit && int'(status) != v; i++) @(negedge clk);
    endtask

    task automatic wait_code(input int v, input int limit);
        for (int i = 0; i < limit && int'(strobe_dly) != v; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        cyc(5);
        rst = 1'b0;
        cyc(1);
        chk("R1 strobe code", int'(strobe_dly), 167);
        chk("R1 sample code", int'(sample_dly), 167);
        chk("R1 status", int'(status), 0);
    endtask

    task automatic t_arming;
        edge_pos = 300;
        skew = 4'd15;
        ctrl = 2'b11;
        cyc(100);
        chk("R2 unarmed 11 ignored code", int'(strobe_dly), 167);
        chk("R2 unarmed 11 ignored status", int'(status), 0);
        ctrl = 2'b00;
        cyc(2);
        ctrl = 2'b10;
        cyc(100);
        chk("R2 armed holds code", int'(strobe_dly), 167);
        ctrl = 2'b11;
        cyc(10);
        chk("R3 no step inside first window", int'(strobe_dly), 167);
        cyc(15);
        chk("R3 first increment", int'(strobe_dly), 168);
        chk("R6 status while searching", int'(status), 0);
        chk("R9 sample follows", int'(sample_dly), 168);
    endtask

    task automatic t_lock;
        int c0;
        wait_code(284, 4000);
        chk("R3 climbs to window edge", int'(strobe_dly), 284);
        cyc(100);
        chk("R6 no lock before 8 windows", int'(status), 0);
        cyc(40);
        chk("R6 locked status", int'(status), 5);
        chk_range("R4 code inside window", int'(strobe_dly), 284, 299);
        c0 = int'(strobe_dly);
        cyc(200);
        chk("R4 aligned code held", int'(strobe_dly), c0);
        chk("R6 lock kept", int'(status), 5);
    endtask

    task automatic t_drift;
        edge_pos = 340;
        cyc(150);
        chk("R7 lock dropped", int'(status), 0);
        wait_status(5, 3000);
        chk("R7 relocked", int'(status), 5);
        chk_range("R7 code follows drift", int'(strobe_dly), 324, 339);
        chk("R9 sample follows drift", int'(sample_dly), int'(strobe_dly));
    endtask

    task automatic t_disable;
        int c0;
        ctrl = 2'b00;
        cyc(3);
        chk("R10 status after disable", int'(status), 0);
        c0 = int'(strobe_dly);
        edge_pos = 600;
        cyc(200);
        chk("R10 code frozen", int'(strobe_dly), c0);
    endtask

    task automatic t_slow;
        int c0;
        c0 = int'(strobe_dly);
        skew = 4'd0;
        edge_pos = c0 + 200;
        ctrl = 2'b10;
        cyc(1);
        ctrl = 2'b11;
        cyc(200);
        chk("R5 narrow window no step yet", int'(strobe_dly), c0);
        cyc(100);
        chk("R5 narrow window one step", int'(strobe_dly), c0 + 1);
    endtask

    task automatic t_saturate;
        skew = 4'd15;
        edge_pos = 5000;
        wait_code(1023, 20000);
        cyc(100);
        chk("R8 upper limit", int'(strobe_dly), 1023);
        chk("R9 sample at upper limit", int'(sample_dly), 1023);
        edge_pos = 0;
        wait_code(0, 20000);
        cyc(100);
        chk("R8 lower limit", int'(strobe_dly), 0);
        chk("R3 decrement reached floor", int'(sample_dly), 0);
    endtask

    initial begin
        t_reset;
        t_arming;
        t_lock;
        t_drift;
        t_disable;
        t_slow;
        t_saturate;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule